// File: doc/BRIEF.md
# SPI Master with Mode-Fault Detection

A byte-wide serial peripheral controller with one fixed clock mode. When its master bit is set, a write to the data register starts an eight-bit exchange. The block drives SCK and shifts the byte out MSB first on MOSI. At the same time it collects the byte coming back on MISO. A prescale field and a rate field set the SCK speed. The select pin can be an automatic chip select, a plain output or a fault input.

When the select pin is an input and the block is an enabled master, a low level on that pin means another master has taken the bus. This is a mode fault. The block sets a fault flag and clears its own enable and master bits. That drops every output enable, so SCK, MOSI and MISO are released. With the master bit cleared, the block acts as a slave clocked by the SCK input. It drives MISO only while its select input is low.

Software reaches the block through a small register port with four addresses. A single interrupt line reports a completed byte or a fault when the interrupt bit is set.

Top module: `spi_port`

## Requirements
- R1: After reset, every register reads zero, all four output enables are low and `irq` is low.
- R2: Register map: address 0 is control (bit0 enable, bit1 master, bit2 interrupt enable, bit3 select-pin drive, bit4 automatic select, bit5 plain select level), address 1 is rate, address 2 is status (bit0 done, bit1 fault), address 3 is data. In master mode a data write while idle starts a transfer. MOSI shows the byte MSB first and changes only on SCK falling edges.
- R3: SCK idles low. Rate bits [2:0] are P and bits [5:3] are R. Each SCK half period lasts (P+1)·2^(R+1) clocks, and the first rising edge comes one half period after the data write.
- R4: MISO is sampled on SCK rising edges. After eight bits, status bit0 sets and the received byte reads back at address 3.
- R5: A data write during a transfer is ignored.
- R6: With bit3 and bit4 set, the select output is low for the whole transfer and high while idle. With bit3 set and bit4 clear, it follows control bit5. `sel_oe` equals bit3.
- R7: When the block is an enabled master with bit3 clear and `sel_i` is low, the transfer aborts. Status bit1 sets, control bits 0 and 1 clear, and the SCK, MOSI and MISO enables drop.
- R8: `irq` is high exactly when bit2 is set and either status flag is set.
- R9: The done flag clears on a data read only after a status read that saw it set. A data read alone leaves it set.
- R10: The fault flag clears on a control write that follows a status read that saw it set. If `sel_i` is still low when the master is re-enabled, the fault returns.
- R11: In slave mode with `sel_i` low, MISO is driven with the shift register MSB. Bits are taken from MOSI on SCK-input rises and shifted on falls, and the byte completes after eight falls. With `sel_i` high, MISO is released and the bit count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for flag clearing) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK output enable |
| sck_i | input | 1 | SCK pin level (slave clock) |
| mosi_o | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI pin level (slave data in) |
| miso_o | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO output enable |
| miso_i | input | 1 | MISO pin level (master data in) |
| sel_o | output | 1 | Select pin drive value |
| sel_oe | output | 1 | Select pin output enable |
| sel_i | input | 1 | Select pin level |

## Verification
The assertions assume that rate and control are not rewritten while a master transfer is running. They also assume that a slave SCK input is never toggled while software writes the data register. Both would mix old and new settings within one byte. The stimulus changes these registers only between transfers and toggles the slave clock only after the data load. It holds each slave clock level for three system clocks, so every input edge is seen once.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8,
  parameter int PW = 3,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  output logic          sel_o,
  output logic          sel_oe,
  input  logic          sel_i
);
  localparam int HCW = PW + (1 << RW) + 1;
  localparam int EW  = $clog2(2 * DW);
  localparam int SBW = $clog2(DW);

  logic [5:0]       ctrl;
  logic [PW+RW-1:0] rate;
  logic             done, fault, done_arm, fault_arm, busy, sck, sck_q, samp;
  logic [DW-1:0]    sh, rxb;
  logic [HCW-1:0]   cnt, half;
  logic [EW-1:0]    edges;
  logic [SBW-1:0]   sbits;
  logic [RW:0]      shamt;

  wire en = ctrl[0], mst = ctrl[1];
  wire fault_now = en & mst & ~ctrl[3] & ~sel_i;
  wire tick = busy & (cnt == half - HCW'(1));
  wire [DW-1:0] shifted = {sh[DW-2:0], samp};

  assign shamt = {1'b0, rate[PW+RW-1:PW]} + (RW+1)'(1);
  assign half  = (HCW'(rate[PW-1:0]) + HCW'(1)) << shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rate <= '0; done <= 1'b0; fault <= 1'b0;
      done_arm <= 1'b0; fault_arm <= 1'b0; busy <= 1'b0; sck <= 1'b0;
      sck_q <= 1'b0; samp <= 1'b0; sh <= '0; rxb <= '0; cnt <= '0;
      edges <= '0; sbits <= '0;
    end else begin
      sck_q <= sck_i;
      if (wr_en && addr == 2'd0) begin
        ctrl <= wdata[5:0];
        if (fault_arm) begin fault <= 1'b0; fault_arm <= 1'b0; end
      end
      if (wr_en && addr == 2'd1) rate <= wdata[PW+RW-1:0];
      if (rd_en && addr == 2'd2) begin
        if (done)  done_arm  <= 1'b1;
        if (fault) fault_arm <= 1'b1;
      end
      if (rd_en && addr == 2'd3 && done_arm) begin
        done <= 1'b0; done_arm <= 1'b0;
      end
      if (wr_en && addr == 2'd3 && !busy && sbits == '0) begin
        sh <= wdata;
        if (en && mst && !fault_now) begin
          busy <= 1'b1; cnt <= '0; edges <= '0;
        end
      end
      if (tick) begin
        cnt   <= '0;
        sck   <= ~sck;
        edges <= edges + EW'(1);
        if (!sck) samp <= miso_i;
        else begin
          sh <= shifted;
          if (edges == EW'(2 * DW - 1)) begin
            busy <= 1'b0; done <= 1'b1; rxb <= shifted;
          end
        end
      end else if (busy) cnt <= cnt + HCW'(1);
      if (en && !mst) begin
        if (sel_i) sbits <= '0;
        else if (sck_i && !sck_q) samp <= mosi_i;
        else if (!sck_i && sck_q) begin
          sh    <= shifted;
          sbits <= sbits + SBW'(1);
          if (sbits == SBW'(DW - 1)) begin
            done <= 1'b1; rxb <= shifted; sbits <= '0;
          end
        end
      end
      if (fault_now) begin
        fault <= 1'b1; ctrl[1:0] <= 2'b00; busy <= 1'b0; sck <= 1'b0;
      end
    end
  end

  assign sck_o   = sck;
  assign sck_oe  = en & mst;
  assign mosi_o  = sh[DW-1];
  assign mosi_oe = en & mst;
  assign miso_o  = sh[DW-1];
  assign miso_oe = en & ~mst & ~sel_i;
  assign sel_oe  = ctrl[3];
  assign sel_o   = ctrl[4] ? ~busy : ctrl[5];
  assign irq     = ctrl[2] & (done | fault);

  always_comb begin
    case (addr)
      2'd0:    rdata = DW'(ctrl);
      2'd1:    rdata = DW'(rate);
      2'd2:    rdata = DW'({fault, done});
      default: rdata = rxb;
    endcase
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_o,
  input logic sck_oe,
  input logic mosi_o,
  input logic mosi_oe,
  input logic miso_oe,
  input logic sel_o,
  input logic sel_oe,
  input logic sel_i,
  input logic irq,
  input logic busy,
  input logic fault,
  input logic c_en,
  input logic c_mst,
  input logic c_ie,
  input logic c_auto
);
  assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o);
  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck_o && $past(sck_o)) |-> $stable(mosi_o));
  assert_auto_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_oe && c_auto) |-> !sel_o);
  assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!sck_oe && !mosi_oe && !miso_oe && !c_en && !c_mst));
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> c_ie);
  assert_slave_miso_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!sel_i && !sck_oe));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .sel_o(sel_o), .sel_oe(sel_oe),
  .sel_i(sel_i), .irq(irq), .busy(busy), .fault(fault), .c_en(ctrl[0]),
  .c_mst(ctrl[1]), .c_ie(ctrl[2]), .c_auto(ctrl[4])
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, sel_o, sel_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, sel_i = 1'b1;

  spi_port i_spi_port (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .sel_o(sel_o), .sel_oe(sel_oe), .sel_i(sel_i));

  int vectors = 0, errors = 0;
  bit ended = 0;

  // behavioural reference state
  int m_ctrl, m_rate, m_done, m_fault, m_darm, m_farm, m_busy, mt, k, psck, ssamp, known;
  logic [7:0] txb, rxm, rxs, sbyte = 8'h00;

  function automatic int half_of(int r);
    return ((r & 7) + 1) * (1 << (((r >> 3) & 7) + 1));
  endfunction

  function automatic int exp_msb();
    if (m_busy) return (txb >> (7 - mt / (2 * half_of(m_rate)))) & 1;
    if (k > 0) return (txb >> (7 - k)) & 1;
    return txb[7];
  endfunction

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rate = 0; m_done = 0; m_fault = 0; m_darm = 0; m_farm = 0;
      m_busy = 0; mt = 0; k = 0; psck = 0; ssamp = 0; known = 1; txb = 0; rxm = 0; rxs = 0;
    end else begin
      int en0, mst0, busy0, k0, fnow, hv;
      en0 = m_ctrl & 1; mst0 = (m_ctrl >> 1) & 1; busy0 = m_busy; k0 = k;
      hv = half_of(m_rate);
      fnow = en0 && mst0 && !((m_ctrl >> 3) & 1) && !sel_i;
      if (wr_en && addr == 0) begin
        m_ctrl = wdata & 63;
        if (m_farm) begin m_fault = 0; m_farm = 0; end
      end
      if (wr_en && addr == 1) m_rate = wdata & 63;
      if (rd_en && addr == 2) begin
        if (m_done) m_darm = 1;
        if (m_fault) m_farm = 1;
      end
      if (rd_en && addr == 3 && m_darm) begin m_done = 0; m_darm = 0; end
      if (busy0) begin
        mt++;
        if (mt == 16 * hv) begin m_busy = 0; m_done = 1; txb = sbyte; rxm = sbyte; end
      end
      if (wr_en && addr == 3 && !busy0 && k0 == 0) begin
        txb = wdata; known = 1;
        if (en0 && mst0 && !fnow) begin m_busy = 1; mt = 0; end
      end
      if (en0 && !mst0) begin
        if (sel_i) begin
          if (k > 0) known = 0;
          k = 0;
        end else if (sck_i && !psck) ssamp = mosi_i;
        else if (!sck_i && psck) begin
          rxs = {rxs[6:0], 1'(ssamp)};
          k++;
          if (k == 8) begin m_done = 1; rxm = rxs; txb = rxs; k = 0; end
        end
      end
      psck = sck_i;
      if (fnow) begin
        if (m_busy) known = 0;
        m_fault = 1; m_ctrl = m_ctrl & ~3; m_busy = 0;
      end
    end
  end

  // emulated remote slave feeding MISO during master transfers
  always @(posedge clk) begin
    #1;
    miso_i = m_busy ? sbyte[7 - mt / (2 * half_of(m_rate))] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic [7:0] er;
      int en, mst;
      en = m_ctrl & 1; mst = (m_ctrl >> 1) & 1;
      chk("R3 sck_o", sck_o, m_busy ? (mt / half_of(m_rate)) % 2 : 0);
      chk("R7 sck_oe", sck_oe, en && mst);
      chk("R7 mosi_oe", mosi_oe, en && mst);
      chk("R11 miso_oe", miso_oe, en && !mst && !sel_i);
      if (known) begin
        chk("R2 mosi_o", mosi_o, exp_msb());
        chk("R11 miso_o", miso_o, exp_msb());
      end
      chk("R6 sel_oe", sel_oe, (m_ctrl >> 3) & 1);
      chk("R6 sel_o", sel_o, ((m_ctrl >> 4) & 1) ? !m_busy : (m_ctrl >> 5) & 1);
      chk("R8 irq", irq, ((m_ctrl >> 2) & 1) && (m_done || m_fault));
      case (addr)
        2'd0: er = 8'(m_ctrl);
        2'd1: er = 8'(m_rate);
        2'd2: er = 8'((m_fault << 1) | m_done);
        default: er = rxm;
      endcase
      chk("R4 rdata", rdata, er);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a);
    @(posedge clk); #1 rd_en = 1; addr = a;
    @(posedge clk); #1 rd_en = 0;
  endtask
  task automatic look(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 addr = a;
    #1 chk(tag, rdata, exp);
  endtask
  task automatic settle();
    while (m_busy) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask
  task automatic rise_delay(input int exp, input string tag);
    int n = 0;
    while (!sck_o && n < 5000) begin @(posedge clk); #1; n++; end
    chk(tag, n, exp);
  endtask
  task automatic slave_bit(input logic b);
    @(posedge clk); #1 mosi_i = b;
    repeat (3) @(posedge clk); #1 sck_i = 1;
    repeat (3) @(posedge clk); #1 sck_i = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    look(2'd0, 8'h00, "R1 ctrl");
    look(2'd2, 8'h00, "R1 status");
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe, sel_oe, irq}, 0);

    // first transfer: fastest rate, automatic select
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h1B);
    sbyte = 8'h3C;
    wr(2'd3, 8'hA5);
    rise_delay(2, "R3 first edge half=2");
    settle();
    look(2'd2, 8'h01, "R4 done");
    look(2'd3, 8'h3C, "R4 rx");
    rd(2'd3);
    look(2'd2, 8'h01, "R9 done kept");
    rd(2'd2); rd(2'd3);
    look(2'd2, 8'h00, "R9 done cleared");

    // slower rate, interrupt on, write while busy
    wr(2'd1, 8'h0A);
    wr(2'd0, 8'h1F);
    sbyte = 8'hC3;
    wr(2'd3, 8'h5A);
    rise_delay(12, "R3 first edge half=12");
    repeat (20) @(posedge clk);
    wr(2'd3, 8'hFF);
    settle();
    look(2'd3, 8'hC3, "R5 rx unchanged");
    chk("R8 irq on done", irq, 1);
    rd(2'd2); rd(2'd3);
    chk("R8 irq off", irq, 0);

    // plain select output
    wr(2'd0, 8'h2B);
    #1 chk("R6 level high", sel_o, 1);
    wr(2'd0, 8'h0B);
    #1 chk("R6 level low", sel_o, 0);

    // mode fault
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    sbyte = 8'h81;
    wr(2'd3, 8'h81);
    repeat (10) @(posedge clk);
    #1 sel_i = 0;
    repeat (2) @(posedge clk);
    look(2'd0, 8'h04, "R7 ctrl cleared");
    look(2'd2, 8'h02, "R7 fault set");
    chk("R7 pins released", {sck_oe, mosi_oe, sck_o}, 0);
    chk("R8 irq on fault", irq, 1);
    rd(2'd2);
    wr(2'd0, 8'h07);
    repeat (2) @(posedge clk);
    look(2'd2, 8'h02, "R10 refault");
    look(2'd0, 8'h04, "R10 refault ctrl");
    #1 sel_i = 1;
    rd(2'd2);
    wr(2'd0, 8'h07);
    look(2'd2, 8'h00, "R10 fault cleared");
    look(2'd0, 8'h07, "R10 reenabled");

    // slave mode
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h96);
    @(posedge clk); #1 sel_i = 0;
    repeat (2) @(posedge clk);
    #1 chk("R11 miso driven", {miso_oe, miso_o}, 2'b11);
    for (int b = 7; b >= 0; b--) slave_bit(8'h4B >> b);
    look(2'd3, 8'h4B, "R11 slave rx");
    look(2'd2, 8'h01, "R11 slave done");
    @(posedge clk); #1 sel_i = 1;
    #1 chk("R11 miso released", miso_oe, 0);
    repeat (4) @(posedge clk);

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule